// File: doc/BRIEF.md
# Low-Power Mode and Reset Controller

This block sequences the run, idle and power-down states of an 8-bit microcontroller core. Software raises one-cycle requests for idle or power-down. The block then gates the core clock, the peripheral clock and the oscillator to match the requested state. It also raises flags that override the external bus strobes and the port drivers. In idle, execution stops but peripherals keep running, and any enabled pending interrupt brings the core back. In power-down the oscillator is stopped. Two things can leave power-down: the reset pin, or an external interrupt pin that is enabled, configured level-sensitive and held low.

A power-down exit has two phases. The first is an oscillator restart wait, modelled by a counter of `WAKE_CYC` cycles. The second is a release phase, which ends only when every qualifying interrupt pin is high again. A one-cycle `resume` pulse marks an interrupt exit, during which the special-function registers are preserved. A reset exit instead goes through the internal reset, which reinitialises them. The raw reset pin is filtered: the internal reset appears only after the pin has stayed high for `RST_CYC` oscillator cycles, and only while the oscillator runs.

`clk` stands for the oscillator clock. `por_n` is a supply-good reset that clears the controller itself.

Top module: `lpm_ctrl`

## Requirements
- R1: `rst_pin` and `xint_n` each pass through two synchroniser flops. `rst_int` goes high once the synchronised reset pin has been high for `RST_CYC` (default 24) consecutive cycles in which the oscillator is live (run, idle or release phase). It drops one cycle after the synchronised pin goes low. A shorter high pulse has no effect. While `rst_int` is high the state is forced to run.
- R2: In run, a one-cycle `idle_req` moves the block to idle at the next edge. In idle `core_clk_en`=0, while `periph_clk_en`=1 and `osc_en`=1.
- R3: In idle, `irq_pend` returns the block to run at the next edge, and `resume` is 1 for exactly that one cycle.
- R4: In run, `pd_req` moves the block to power-down at the next edge. In power-down `osc_en`, `periph_clk_en` and `core_clk_en` are all 0. When `idle_req` and `pd_req` arrive together, power-down wins.
- R5: In power-down, a wake is started only by the synchronised reset pin or by a synchronised interrupt pin i that is low with `xint_en[i]`=1 and `xint_lvl[i]`=1 (1 = level-sensitive). An edge-configured pin or a disabled pin leaves the block in power-down.
- R6: A wake spends `WAKE_CYC` (default 64) cycles in a restart wait, with `osc_en`=1 and both other clock enables at 0. Releasing the pin during this wait does not shorten it.
- R7: After the wait, the block stays in the release phase (`pd_st`=1, `osc_en`=1) while any qualifying pin is low. When none is low, it returns to run with a one-cycle `resume`.
- R8: If the synchronised reset pin is high when the wait ends, the block returns to run without `resume`, and the internal reset then follows per R1.
- R9: `ctl_force`=1 in idle and power-down (including the wait and release phases), and 0 in run. `ctl_level` is 1 in idle and 0 in power-down, giving the forced level of the address strobe and the program-store strobe.
- R10: `p0_float`=1 when `ext_code`=1 and the block is in idle or power-down. `p2_latch`=1 throughout power-down, so port 2 drives its latch rather than the address.
- R11: `idle_req` and `pd_req` are ignored outside run and while `rst_int` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Supply-good reset of the controller, active low |
| rst_pin | input | 1 | Raw reset pin, active high |
| idle_req | input | 1 | Software idle request pulse |
| pd_req | input | 1 | Software power-down request pulse |
| irq_pend | input | 1 | Some enabled interrupt is pending |
| xint_n | input | NX | External interrupt pins, active low |
| xint_en | input | NX | Per-pin interrupt enable |
| xint_lvl | input | NX | Per-pin trigger: 1 = level, 0 = edge |
| ext_code | input | 1 | Code is fetched from external memory |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator run enable |
| rst_int | output | 1 | Filtered internal reset |
| resume | output | 1 | One-cycle pulse on an interrupt return to run |
| idle_st | output | 1 | Idle state flag |
| pd_st | output | 1 | Power-down flag (including wait and release) |
| ctl_force | output | 1 | Override address and program-store strobes |
| ctl_level | output | 1 | Level forced onto those strobes |
| p0_float | output | 1 | Float the low address/data port |
| p2_latch | output | 1 | High address port drives its latch |

## Verification
The hardest situation to reach is an interrupt wake in which the pin goes high again before the restart wait has expired. A naive design completes the return early in that case. The stimulus reaches it by holding a level-enabled pin low for a few cycles inside the wait and then releasing it. A second case keeps the pin low well past the wait, to show the release phase holding. The same power-down entry is also tried with an edge-configured pin and with a disabled pin to show that neither wakes the block. A reset-driven wake from power-down is checked as well: it must return to run through the internal reset filter with no `resume`.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int NX       = 2,
  parameter int RST_CYC  = 24,
  parameter int WAKE_CYC = 64
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_pin,
  input  logic          idle_req,
  input  logic          pd_req,
  input  logic          irq_pend,
  input  logic [NX-1:0] xint_n,
  input  logic [NX-1:0] xint_en,
  input  logic [NX-1:0] xint_lvl,
  input  logic          ext_code,
  output logic          core_clk_en,
  output logic          periph_clk_en,
  output logic          osc_en,
  output logic          rst_int,
  output logic          resume,
  output logic          idle_st,
  output logic          pd_st,
  output logic          ctl_force,
  output logic          ctl_level,
  output logic          p0_float,
  output logic          p2_latch
);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam int WW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;

  typedef enum logic [2:0] {S_RUN, S_IDLE, S_PD, S_WARM, S_HOLD} st_t;

  st_t           st;
  logic [1:0]    rsync;
  logic [NX-1:0] xs1, xs2;
  logic [RW-1:0] rcnt;
  logic [WW-1:0] wcnt;

  logic rs, live, wake_lvl;
  assign rs       = rsync[1];
  assign live     = (st == S_RUN) || (st == S_IDLE) || (st == S_HOLD);
  assign wake_lvl = |(~xs2 & xint_en & xint_lvl);
  assign rst_int  = (rcnt == RW'(RST_CYC));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rsync <= '0;
      xs1   <= '1;
      xs2   <= '1;
    end else begin
      rsync <= {rsync[0], rst_pin};
      xs1   <= xint_n;
      xs2   <= xs1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                     rcnt <= '0;
    else if (!rs)                   rcnt <= '0;
    else if (live && !rst_int)      rcnt <= rcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st     <= S_RUN;
      wcnt   <= '0;
      resume <= 1'b0;
    end else begin
      resume <= 1'b0;
      if (rst_int) begin
        st <= S_RUN;
      end else begin
        unique case (st)
          S_RUN:  if (pd_req) st <= S_PD;
                  else if (idle_req) st <= S_IDLE;
          S_IDLE: if (irq_pend) begin
                    st     <= S_RUN;
                    resume <= 1'b1;
                  end
          S_PD:   if (rs || wake_lvl) begin
                    st   <= S_WARM;
                    wcnt <= '0;
                  end
          S_WARM: if (wcnt == WW'(WAKE_CYC - 1)) st <= rs ? S_RUN : S_HOLD;
                  else wcnt <= wcnt + 1'b1;
          S_HOLD: if (!wake_lvl) begin
                    st     <= S_RUN;
                    resume <= 1'b1;
                  end
          default: st <= S_RUN;
        endcase
      end
    end
  end

  assign idle_st       = (st == S_IDLE);
  assign pd_st         = (st == S_PD) || (st == S_WARM) || (st == S_HOLD);
  assign core_clk_en   = (st == S_RUN);
  assign periph_clk_en = (st == S_RUN) || (st == S_IDLE);
  assign osc_en        = (st != S_PD);
  assign ctl_force     = idle_st || pd_st;
  assign ctl_level     = idle_st;
  assign p0_float      = ext_code && ctl_force;
  assign p2_latch      = pd_st;
endmodule

module lpm_ctrl_chk (
  input logic clk,
  input logic por_n,
  input logic idle_req,
  input logic pd_req,
  input logic rst_int,
  input logic idle_st,
  input logic pd_st,
  input logic core_clk_en,
  input logic periph_clk_en,
  input logic resume,
  input logic ctl_force,
  input logic ctl_level
);
  p_rst_run_r1: assert property (@(posedge clk) disable iff (!por_n)
    rst_int |=> (!idle_st && !pd_st));
  p_idle_entry_r2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(idle_st) |-> ($past(idle_req) && !$past(pd_req)));
  p_pd_prio_r4: assert property (@(posedge clk) disable iff (!por_n)
    (!idle_st && !pd_st && !rst_int && pd_req) |=> pd_st);
  p_pd_clk_r4: assert property (@(posedge clk) disable iff (!por_n)
    pd_st |-> (!core_clk_en && !periph_clk_en));
  p_resume_r7: assert property (@(posedge clk) disable iff (!por_n)
    resume |-> (core_clk_en && !pd_st && !idle_st));
  p_ctl_r9: assert property (@(posedge clk) disable iff (!por_n)
    ctl_force |-> (ctl_level == idle_st));
  p_req_ign_r11: assert property (@(posedge clk) disable iff (!por_n)
    (pd_st && idle_req) |=> !idle_st);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .idle_req(idle_req), .pd_req(pd_req),
  .rst_int(rst_int), .idle_st(idle_st), .pd_st(pd_st),
  .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
  .resume(resume), .ctl_force(ctl_force), .ctl_level(ctl_level)
);

// File: tb/sim_lpm_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_ctrl;
  localparam int NX = 2, RC = 24, WC = 64;
  logic clk = 0, por_n = 0, rst_pin = 0, idle_req = 0, pd_req = 0, irq_pend = 0, ext_code = 1;
  logic [NX-1:0] xint_n = '1, xint_en = '0, xint_lvl = '0;
  logic core_clk_en, periph_clk_en, osc_en, rst_int, resume, idle_st, pd_st;
  logic ctl_force, ctl_level, p0_float, p2_latch;
  int n_run = 0, n_fail = 0, cyc = 0;
  bit saw_res = 0;

  always #2 clk = ~clk;

  lpm_ctrl #(.NX(NX), .RST_CYC(RC), .WAKE_CYC(WC)) u0 (.*);

  // behavioural reference: 0 run, 1 idle, 2 pd, 3 restart wait, 4 release
  int ms = 0, mc = 0, wc = 0;
  int rq[$] = '{0, 0};
  logic [NX-1:0] xq[$] = '{'1, '1};
  bit mres = 0;

  always @(posedge clk) begin
    if (!por_n) begin
      ms = 0; mc = 0; wc = 0; mres = 0; rq = '{0, 0}; xq = '{'1, '1};
    end else begin
      int r; bit live, rint, wl;
      r = rq[1];
      live = (ms == 0) || (ms == 1) || (ms == 4);
      rint = (mc == RC);
      wl = |(~xq[1] & xint_en & xint_lvl);
      mres = 0;
      if (rint) ms = 0;
      else case (ms)
        0: if (pd_req) ms = 2; else if (idle_req) ms = 1;
        1: if (irq_pend) begin ms = 0; mres = 1; end
        2: if (r != 0 || wl) begin ms = 3; wc = 0; end
        3: if (wc == WC - 1) ms = (r != 0) ? 0 : 4; else wc++;
        4: if (!wl) begin ms = 0; mres = 1; end
        default: ms = 0;
      endcase
      if (r == 0) mc = 0; else if (live && !rint) mc++;
      rq = '{int'(rst_pin), rq[0]};
      xq = '{xint_n, xq[0]};
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (resume) saw_res = 1;
    if (por_n) begin
      bit eidle, epd;
      eidle = (ms == 1); epd = (ms >= 2);
      chk(rst_int == (mc == RC), "R1 rst_int", rst_int, mc == RC);
      chk(idle_st == eidle, "R2 idle_st", idle_st, eidle);
      chk(core_clk_en == (ms == 0), "R2 core_clk_en", core_clk_en, ms == 0);
      chk(resume == mres, "R3 resume", resume, mres);
      chk(pd_st == epd, "R4 pd_st", pd_st, epd);
      chk(osc_en == (ms != 2), "R6 osc_en", osc_en, ms != 2);
      chk(periph_clk_en == (ms <= 1), "R4 periph_clk_en", periph_clk_en, ms <= 1);
      chk(ctl_force == (eidle || epd), "R9 ctl_force", ctl_force, eidle || epd);
      chk(ctl_level == eidle, "R9 ctl_level", ctl_level, eidle);
      chk(p0_float == (ext_code && (eidle || epd)), "R10 p0_float", p0_float, ext_code && (eidle || epd));
      chk(p2_latch == epd, "R10 p2_latch", p2_latch, epd);
    end
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_idle(); @(negedge clk); idle_req = 1; @(negedge clk); idle_req = 0; endtask
  task automatic pulse_pd();   @(negedge clk); pd_req = 1;   @(negedge clk); pd_req = 0;   endtask

  initial begin
    step(3);
    chk(core_clk_en && !rst_int && !idle_st && !pd_st, "R1 reset state", core_clk_en, 1);
    @(negedge clk); por_n = 1;
    step(2);
    // R2 idle entry, R9/R10 overrides
    pulse_idle(); step(1);
    chk(idle_st && !core_clk_en && periph_clk_en && osc_en, "R2 idle clocks", idle_st, 1);
    chk(ctl_force && ctl_level && p0_float && !p2_latch, "R9 idle pins", ctl_level, 1);
    // R11 pd request in idle ignored
    pulse_pd(); step(1);
    chk(idle_st && !pd_st, "R11 pd_req in idle", pd_st, 0);
    // R3 idle exit
    saw_res = 0;
    @(negedge clk); irq_pend = 1; @(negedge clk); irq_pend = 0; step(1);
    chk(core_clk_en && saw_res, "R3 idle exit resume", saw_res, 1);
    // R4 priority
    @(negedge clk); idle_req = 1; pd_req = 1; @(negedge clk); idle_req = 0; pd_req = 0; step(1);
    chk(pd_st && !osc_en && !idle_st, "R4 pd priority", pd_st, 1);
    chk(ctl_force && !ctl_level && p2_latch, "R9 pd pins", ctl_level, 0);
    // R5 edge-configured and disabled pins do not wake
    @(negedge clk); xint_en = 2'b01; xint_lvl = 2'b00; xint_n = 2'b10; step(12);
    chk(pd_st && !osc_en, "R5 edge pin ignored", osc_en, 0);
    @(negedge clk); xint_en = 2'b00; xint_lvl = 2'b11; step(12);
    chk(pd_st && !osc_en, "R5 disabled pin ignored", osc_en, 0);
    @(negedge clk); xint_n = 2'b11; xint_en = 2'b01; xint_lvl = 2'b01; step(4);
    // R6 short low pulse: wait not shortened
    saw_res = 0;
    @(negedge clk); xint_n = 2'b10; step(4); xint_n = 2'b11; step(10);
    chk(pd_st && osc_en && !saw_res, "R6 wait not cut short", pd_st, 1);
    step(WC);
    chk(!pd_st && core_clk_en && saw_res, "R7 return after wait", saw_res, 1);
    // R7 pin held past wait
    pulse_pd(); saw_res = 0;
    @(negedge clk); xint_n = 2'b10; step(WC + 20);
    chk(pd_st && osc_en && !saw_res, "R7 hold while low", pd_st, 1);
    pulse_idle(); step(1);
    chk(!idle_st && pd_st, "R11 idle_req in hold", idle_st, 0);
    @(negedge clk); xint_n = 2'b11; step(5);
    chk(!pd_st && saw_res, "R7 release completes", saw_res, 1);
    // R8 reset wake
    pulse_pd(); saw_res = 0;
    @(negedge clk); rst_pin = 1; step(WC + 8);
    chk(!pd_st && !saw_res, "R8 reset wake no resume", saw_res, 0);
    step(RC);
    chk(rst_int == 1, "R8 internal reset follows", rst_int, 1);
    pulse_pd(); step(1);
    chk(!pd_st, "R11 pd_req during rst_int", pd_st, 0);
    @(negedge clk); rst_pin = 0; step(4);
    chk(rst_int == 0, "R1 rst_int release", rst_int, 0);
    // R1 short pulse filtered, long pulse accepted
    @(negedge clk); rst_pin = 1; step(RC - 4); rst_pin = 0; step(6);
    chk(rst_int == 0, "R1 short pulse", rst_int, 0);
    pulse_idle();
    @(negedge clk); rst_pin = 1; step(RC + 4);
    chk(rst_int == 1 && !idle_st, "R1 long pulse from idle", rst_int, 1);
    @(negedge clk); rst_pin = 0; step(5);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule